// File: doc/BRIEF.md
# Dual Timer/Counter with Selectable Count Modes

This block holds two independent count channels, each made of a low byte, a high byte, a run bit and a sticky overflow flag. It also has one shared configuration byte. A channel advances on a tick derived from the system clock divided by `PRESCALE`. It can instead advance on falling transitions of its own external count pin, sampled at that tick rate. When a channel's gate option is on, it also needs its gate pin to be high before it counts.

Four count arrangements are available per channel:
- a 13-bit counter built from the five low bits of the low byte and all of the high byte;
- a full 16-bit counter;
- an 8-bit counter in the low byte that reloads from the high byte when it wraps;
- a split arrangement, in which channel 0 becomes two separate 8-bit counters.

In the split arrangement, the second of those counters borrows channel 1's run bit and overflow flag. Software reads and writes every register through a simple byte-wide port. The only other outputs are the two overflow flags, which feed an interrupt controller. Each flag is cleared either by that controller's acknowledge input or by a software write.

Top module: `timer_pair`

## Requirements
- R1: After reset, every count byte, the configuration byte, both run bits and both overflow flags are 0, and `ovf` is 2'b00.
- R2: In timer mode, a running channel with gating off advances once per `PRESCALE` clocks. Any window of N·`PRESCALE` consecutive running clocks gives exactly N counts, and nothing changes between ticks. In counter mode (source bit = 1), the channel advances once for each 1-to-0 change of its `cnt_pin` bit seen on two consecutive tick-rate samples.
- R3: With the gate bit set, a channel counts only while its run bit is 1 and its `gate_pin` bit is 1. With the gate bit clear, the run bit alone enables it.
- R4: Mode 0 (mode field 2'b00) counts through the 13-bit value {high byte, low byte[4:0]}. Bits [7:5] of the low byte are preserved. The step from high=FFh, low[4:0]=1Fh wraps to 0 and sets the flag.
- R5: Mode 1 (2'b01) counts {high, low} as 16 bits. The step from FFFFh gives 0000h and sets the flag.
- R6: Mode 2 (2'b10) counts the low byte only. The step from FFh loads the low byte with the high byte and sets the flag.
- R7: When channel 0 is in mode 3 (2'b11), its low byte is an 8-bit counter under channel 0's controls and sets flag 0. Its high byte counts every tick while run bit 1 is set, and sets flag 1 on the step from FFh.
- R8: Configuration byte bits [3:0] control channel 0 and bits [7:4] control channel 1. Each nibble holds gate (bit 3), source (bit 2) and mode (bits 1:0). It is written only as a whole byte.
- R9: A flag stays set until `ack` for that channel is 1, or until a control write carries a 1 in the flag's bit position. An overflow in the same cycle takes priority over the clear.
- R10: A software write to a count byte takes priority over an increment of that byte in the same cycle.
- R11: Register addresses:
  - 0: configuration byte.
  - 1: control byte. Bit 0 is run 0 and bit 1 is run 1; a write loads these bits. Bit 2 is flag 0 and bit 3 is flag 1; a write of 1 clears the flag. All bits read back.
  - 2 and 3: channel 0 low and high bytes.
  - 4 and 5: channel 1 low and high bytes.
  - Any other address reads 0. `rd_data` is combinational.
- R12: Channel 1 in mode 3 holds its count. While channel 0 is in mode 3, channel 1 still counts in its own mode but never sets flag 1 itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| cnt_pin | input | 2 | External count inputs, bit n for channel n |
| gate_pin | input | 2 | External gate inputs, bit n for channel n |
| ack | input | 2 | Interrupt acknowledge, clears flag n |
| ovf | output | 2 | Overflow flags |

## Verification
The hardest case to reach is a software write that lands on the same clock as a tick-driven increment, because the prescaler phase cannot be seen at the ports. The stimulus holds the write strobe on one count byte for a full prescale period while the channel runs. It reads the byte back after every edge, so one of those edges is certain to collide with a tick. Exact count windows are built the same way: the run bit stays high for a whole multiple of the prescale period, which fixes the number of ticks whatever the phase. Counter-mode pulses are held for two tick periods per level.

// File: rtl/timer_pair.sv
module timer_pair #(
  parameter int PRESCALE = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] ack,
  output logic [1:0] ovf
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pre;
  logic [7:0] cfg, lo0, hi0, lo1, hi1;
  logic [7:0] lo0_n, hi0_n, lo1_n, hi1_n;
  logic [1:0] run, flag, smp, en, ev;
  logic [16:0] r0, r1;
  logic tick, split, set0, set1, wr_ctl;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [13:0] s13;
    logic [16:0] s16;
    s13 = {1'b0, hi, lo[4:0]} + 14'd1;
    s16 = {1'b0, hi, lo} + 17'd1;
    case (m)
      2'd0:    step = {s13[13], s13[12:5], lo[7:5], s13[4:0]};
      2'd1:    step = s16;
      2'd2:    step = (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: step = {1'b0, hi, lo};
    endcase
  endfunction

  assign tick   = (pre == PW'(PRESCALE - 1));
  assign split  = (cfg[1:0] == 2'd3);
  assign wr_ctl = wr_en && (wr_addr == 3'd1);
  assign en     = run & (~{cfg[7], cfg[3]} | gate_pin);
  assign ev     = {2{tick}} & en & (~{cfg[6], cfg[2]} | (smp & ~cnt_pin));
  assign ovf    = flag;

  always_comb begin
    r0 = step(cfg[1:0], lo0, hi0);
    r1 = step(cfg[5:4], lo1, hi1);
    lo0_n = lo0; hi0_n = hi0; lo1_n = lo1; hi1_n = hi1;
    set0 = 1'b0; set1 = 1'b0;
    if (split) begin
      if (ev[0]) begin
        lo0_n = lo0 + 8'd1;
        set0  = (lo0 == 8'hFF);
      end
      if (tick && run[1]) begin
        hi0_n = hi0 + 8'd1;
        set1  = (hi0 == 8'hFF);
      end
    end else if (ev[0]) begin
      {set0, hi0_n, lo0_n} = r0;
    end
    if (ev[1]) begin
      lo1_n = r1[7:0];
      hi1_n = r1[15:8];
      if (!split) set1 = r1[16];
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = cfg;
      3'd1:    rd_data = {4'b0, flag, run};
      3'd2:    rd_data = lo0;
      3'd3:    rd_data = hi0;
      3'd4:    rd_data = lo1;
      3'd5:    rd_data = hi1;
      default: rd_data = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      smp  <= 2'b00;
      cfg  <= 8'd0;
      run  <= 2'b00;
      flag <= 2'b00;
      lo0  <= 8'd0;
      hi0  <= 8'd0;
      lo1  <= 8'd0;
      hi1  <= 8'd0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) smp <= cnt_pin;
      if (wr_en && wr_addr == 3'd0) cfg <= wr_data;
      if (wr_ctl) run <= wr_data[1:0];
      flag <= (flag & ~ack & ~(wr_ctl ? wr_data[3:2] : 2'b00)) | {set1, set0};
      lo0 <= (wr_en && wr_addr == 3'd2) ? wr_data : lo0_n;
      hi0 <= (wr_en && wr_addr == 3'd3) ? wr_data : hi0_n;
      lo1 <= (wr_en && wr_addr == 3'd4) ? wr_data : lo1_n;
      hi1 <= (wr_en && wr_addr == 3'd5) ? wr_data : hi1_n;
    end
  end
endmodule

module timer_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] ack,
  input logic [1:0] ovf,
  input logic       tick,
  input logic [7:0] cfg,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> ovf == 2'b00);

  assert_tick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1));

  assert_wrap16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[0]) && !$past(wr_en) && $past(cfg[1:0]) == 2'd1 |-> lo0 == 8'd0 && hi0 == 8'd0);

  assert_flag0_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] && !ack[0] && !(wr_en && wr_addr == 3'd1) |=> ovf[0]);

  assert_flag1_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[1] && !ack[1] && !(wr_en && wr_addr == 3'd1) |=> ovf[1]);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd2 |=> lo0 == $past(wr_data));

  assert_ch1_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[5:4] == 2'd3 && !wr_en |=> $stable(lo1) && $stable(hi1));
endmodule

bind timer_pair timer_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ack(ack), .ovf(ovf), .tick(tick), .cfg(cfg),
  .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1)
);

// File: tb/tb_timer_pair.sv
module tb_timer_pair;
  localparam int PRE = 12;

  // {cfg, lo, hi, gate_pin0, ticks, exp_lo, exp_hi, exp_flag}
  localparam logic [63:0] VEC [0:7] = '{
    64'h01_FE_FF_00_03_01_00_01,
    64'h01_10_00_00_05_15_00_00,
    64'h00_FE_FF_00_03_E1_00_01,
    64'h00_1F_05_00_01_00_06_00,
    64'h02_FD_80_00_04_81_80_01,
    64'h02_10_20_00_02_12_20_00,
    64'h09_00_00_00_04_00_00_00,
    64'h09_00_00_01_04_04_00_00
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [1:0] cnt_pin = 0, gate_pin = 0, ack = 0, ovf;
  int checks = 0, failures = 0;
  logic [7:0] v;

  timer_pair #(.PRESCALE(PRE)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic run_for(input logic [1:0] r, input int n);
    wr(3'd1, {6'd0, r});
    repeat (n * PRE - 2) @(negedge clk);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", {8'd0, v}, 16'd0);
    end
    chk("R1 ovf", {14'd0, ovf}, 16'd0);

    // vector table: R2 R3 R4 R5 R6 on channel 0
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, 8'h0C);
      wr(3'd0, VEC[i][63:56]);
      wr(3'd2, VEC[i][55:48]);
      wr(3'd3, VEC[i][47:40]);
      gate_pin[0] = VEC[i][32];
      run_for(2'b01, int'(VEC[i][31:24]));
      rd(3'd2, v);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d low", i), {8'd0, v}, {8'd0, VEC[i][23:16]});
      rd(3'd3, v);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d high", i), {8'd0, v}, {8'd0, VEC[i][15:8]});
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d flag", i), {15'd0, ovf[0]}, {15'd0, VEC[i][0]});
    end
    gate_pin = 0;

    // R9 control write clears flag 0
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_for(2'b01, 1);
    chk("R9 flag set", {15'd0, ovf[0]}, 16'd1);
    rd(3'd1, v);
    chk("R11 ctrl readback", {8'd0, v}, 16'h0004);
    wr(3'd1, 8'h04);
    chk("R9 ctrl clear", {15'd0, ovf[0]}, 16'd0);

    // R8 channel 1 in upper nibble, mode 1
    wr(3'd0, 8'h10); wr(3'd2, 8'h33); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    run_for(2'b10, 1);
    rd(3'd4, v); chk("R8 ch1 low", {8'd0, v}, 16'h0000);
    rd(3'd5, v); chk("R8 ch1 high", {8'd0, v}, 16'h0000);
    rd(3'd2, v); chk("R8 ch0 untouched", {8'd0, v}, 16'h0033);
    chk("R8 ovf", {14'd0, ovf}, 16'b10);
    @(negedge clk); ack = 2'b10; @(negedge clk); ack = 0;
    chk("R9 ack clear", {14'd0, ovf}, 16'b00);

    // R2 counter mode: three falling edges on cnt_pin[0]
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    for (int k = 0; k < 3; k++) begin
      cnt_pin[0] = 1; repeat (2 * PRE) @(negedge clk);
      cnt_pin[0] = 0; repeat (2 * PRE) @(negedge clk);
    end
    wr(3'd1, 8'h00);
    rd(3'd2, v); chk("R2 pin edges", {8'd0, v}, 16'd3);

    // R7 split: both halves of channel 0 wrap
    wr(3'd0, 8'h03); wr(3'd2, 8'hFE); wr(3'd3, 8'hFE);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    run_for(2'b11, 2);
    rd(3'd2, v); chk("R7 split low", {8'd0, v}, 16'h0000);
    rd(3'd3, v); chk("R7 split high", {8'd0, v}, 16'h0000);
    chk("R7 flags", {14'd0, ovf}, 16'b11);
    wr(3'd1, 8'h0C);

    // R12 ch1 wraps during split but flag 1 comes only from ch0 high
    wr(3'd2, 8'h00); wr(3'd3, 8'h10); wr(3'd4, 8'h1F); wr(3'd5, 8'hFF);
    run_for(2'b10, 1);
    rd(3'd3, v); chk("R7 split high tick", {8'd0, v}, 16'h0011);
    rd(3'd4, v); chk("R12 ch1 wrapped", {8'd0, v}, 16'h0000);
    chk("R12 no ch1 flag", {14'd0, ovf}, 16'b00);

    // R12 ch1 mode 3 holds
    wr(3'd0, 8'h30); wr(3'd4, 8'h42);
    run_for(2'b10, 3);
    rd(3'd4, v); chk("R12 ch1 hold", {8'd0, v}, 16'h0042);

    // R10 write wins over increment across a full prescale period
    wr(3'd0, 8'h01); wr(3'd1, 8'h01);
    @(negedge clk); wr_en = 1; wr_addr = 3'd2; wr_data = 8'h55; rd_addr = 3'd2;
    begin
      int bad = 0;
      for (int k = 0; k < PRE; k++) begin
        @(negedge clk); #1;
        if (rd_data !== 8'h55) bad++;
      end
      chk("R10 write priority", 16'(bad), 16'd0);
    end
    wr_en = 0;
    wr(3'd1, 8'h00);

    // R11 unmapped read
    rd(3'd7, v); chk("R11 unmapped", {8'd0, v}, 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule